// File: doc/BRIEF.md
# CEC Start Bit Validator

This block watches the single-wire consumer-electronics control line and decides, for every falling edge it treats as a candidate, whether that edge begins a well-formed start bit. All timing is measured in ticks of a slow sampling strobe (nominally 32.768 kHz) that the surrounding logic supplies as a one-cycle enable on the system clock. The line is first passed through a synchroniser. Edges are then recognised only on strobe cycles. A candidate is accepted when the line returns high inside a low-time window and then falls again inside a total-period window.

Each of the four window bounds is a fixed base moved outward (the later bounds) or inward toward the falling edge (the earlier bounds) by its own 3-bit adjustment. The bounds are captured when a candidate begins, so changes to the adjustments made in the middle of a bit have no effect on that bit. The result is reported as a one-cycle accept pulse or a one-cycle error pulse. A neighbouring decoder drives a level that says a message is still open. When a valid start bit arrives while that level is high, a restart pulse comes out with the accept pulse. That restart pulse is the maximum-period error for the ACK bit that was pending. While a message is open, rejected candidates are normal data-bit edges and are dropped silently.

Top module: `cec_start_validator`

## Requirements
- R1: The line input passes through a two-stage synchroniser and is compared with its previous strobe-sampled value only on cycles where `tick` is 1. During reset and after it, all three output pulses are 0. The line is taken to be idle high.
- R2: Elapsed time counts strobe ticks from the candidate's falling edge. The rising edge is in window when elapsed is at least 115 minus `adj_rise_early` and at most 128 plus `adj_rise_late`. The closing falling edge is in window when elapsed is at least 141 minus `adj_per_short` and at most 154 plus `adj_per_long`. All bounds are inclusive.
- R3: When both edges are in window, `start_ok` is 1 for exactly one clock. That clock is the one after the strobe cycle on which the closing fall is detected. `start_ok` and `start_err` are never 1 together.
- R4: A rising edge earlier than the low-time window is an error. So is the line still being low when elapsed passes the late rise bound. Either case gives a one-clock `start_err` the clock after that strobe cycle.
- R5: A closing fall earlier than the period window is an error. So is the line still being high when elapsed passes the long period bound. Either case gives a one-clock `start_err`.
- R6: After an accept or an error, the block is idle until the next falling edge, and rising edges seen while idle are ignored. The falling edge that ends a candidate, whether it is accepted or rejected, never starts a new candidate.
- R7: The four bounds are captured on the strobe cycle that starts a candidate. Adjustment changes after that point do not affect the candidate.
- R8: If `msg_open` is 1 on the strobe cycle where a candidate is accepted, `restart_err` is 1 in the same clock as `start_ok`. `restart_err` is never 1 without `start_ok`.
- R9: If `msg_open` is 1 on the strobe cycle where a candidate is rejected, no `start_err` pulse is produced.
- R10: While `en` is 0, the block returns to idle and produces no pulse. In the clock after any clock with `en` at 0, no pulse is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Validator enable; low forces idle |
| tick | input | 1 | One-cycle sampling strobe (time base) |
| cec_line | input | 1 | Raw, asynchronous control line level |
| msg_open | input | 1 | High while a message is in progress (end of message not yet seen) |
| adj_rise_early | input | 3 | Ticks removed from the earliest-rise bound |
| adj_rise_late | input | 3 | Ticks added to the latest-rise bound |
| adj_per_short | input | 3 | Ticks removed from the minimum-period bound |
| adj_per_long | input | 3 | Ticks added to the maximum-period bound |
| start_ok | output | 1 | One-cycle pulse: valid start bit |
| start_err | output | 1 | One-cycle pulse: start bit timing error |
| restart_err | output | 1 | One-cycle pulse with `start_ok`: start bit arrived mid-message |

## Verification
A captured window or a tick count that is off by even one tick shows at the ports only at a bound. A closing edge placed exactly on a bound then turns from accept into error, or from error into accept, one clock after the strobe that carries it. The bench therefore drives each edge onto, or one tick past, each of the four bounds, with both zero and full adjustment. A state register that fails to return to idle shows later, when the next idle-time edge turns into an extra pulse. If it does not return in time, the candidate after it loses its pulse. The scoreboard catches either case at the pulse that follows, at most one bit period (about 160 ticks) later.

// File: rtl/cec_sb_pkg.sv
package cec_sb_pkg;

  // tick counter width and adjustment width
  localparam int CW    = 8;
  localparam int ADJ_W = 3;

  typedef logic [CW-1:0]    cnt_t;
  typedef logic [ADJ_W-1:0] adj_t;

  typedef enum logic [1:0] {
    SB_IDLE = 2'd0,
    SB_LOW  = 2'd1,
    SB_HIGH = 2'd2
  } sb_state_e;

  // captured acceptance windows, in ticks since the opening fall
  typedef struct packed {
    cnt_t rise_lo;
    cnt_t rise_hi;
    cnt_t per_lo;
    cnt_t per_hi;
  } win_t;

  // bound moved toward the opening fall
  function automatic cnt_t pull_in(cnt_t base, adj_t adj);
    return base - cnt_t'(adj);
  endfunction

  // bound moved away from the opening fall
  function automatic cnt_t push_out(cnt_t base, adj_t adj);
    return base + cnt_t'(adj);
  endfunction

  // counter step that sticks at all-ones
  function automatic cnt_t sat_inc(cnt_t v);
    return (v == '1) ? v : v + cnt_t'(1);
  endfunction

  function automatic logic in_span(cnt_t v, cnt_t lo, cnt_t hi);
    return (v >= lo) && (v <= hi);
  endfunction

endpackage

// File: rtl/cec_sb_sync.sv
module cec_sb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_raw,
  output logic fall,
  output logic rise
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;
  logic              line_s;

  assign line_s = sh_q[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= line_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], line_raw};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_q <= 1'b1;
    else if (tick) prev_q <= line_s;
  end

  assign fall = tick & prev_q & ~line_s;
  assign rise = tick & ~prev_q & line_s;

endmodule

// File: rtl/cec_sb_window.sv
module cec_sb_window
  import cec_sb_pkg::*;
#(
  parameter int RISE_EARLY_BASE = 115,
  parameter int RISE_LATE_BASE  = 128,
  parameter int PER_SHORT_BASE  = 141,
  parameter int PER_LONG_BASE   = 154
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  adj_t adj_rise_early,
  input  adj_t adj_rise_late,
  input  adj_t adj_per_short,
  input  adj_t adj_per_long,
  output win_t win_q
);

  localparam cnt_t RE_B = cnt_t'(RISE_EARLY_BASE);
  localparam cnt_t RL_B = cnt_t'(RISE_LATE_BASE);
  localparam cnt_t PS_B = cnt_t'(PER_SHORT_BASE);
  localparam cnt_t PL_B = cnt_t'(PER_LONG_BASE);

  win_t win_c;

  always_comb begin
    win_c.rise_lo = pull_in (RE_B, adj_rise_early);
    win_c.rise_hi = push_out(RL_B, adj_rise_late);
    win_c.per_lo  = pull_in (PS_B, adj_per_short);
    win_c.per_hi  = push_out(PL_B, adj_per_long);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '{rise_lo: RE_B, rise_hi: RL_B, per_lo: PS_B, per_hi: PL_B};
    end else if (load) begin
      win_q <= win_c;
    end
  end

endmodule

// File: rtl/cec_sb_fsm.sv
module cec_sb_fsm
  import cec_sb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic fall,
  input  logic rise,
  input  logic msg_open,
  input  win_t win,
  output logic load,
  output logic busy,
  output logic ok_q,
  output logic err_q,
  output logic restart_q
);

  sb_state_e st_q, st_d;
  cnt_t      cnt_q, cnt_d, elapsed;
  logic      pass, fail;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    pass    = 1'b0;
    fail    = 1'b0;
    elapsed = sat_inc(cnt_q);
    if (!en) begin
      st_d = SB_IDLE;
    end else if (tick) begin
      case (st_q)
        SB_IDLE: begin
          if (fall) begin
            st_d  = SB_LOW;
            cnt_d = '0;
            load  = 1'b1;
          end
        end
        SB_LOW: begin
          cnt_d = elapsed;
          if (rise) begin
            if (in_span(elapsed, win.rise_lo, win.rise_hi)) st_d = SB_HIGH;
            else                                             fail = 1'b1;
          end else if (elapsed > win.rise_hi) begin
            fail = 1'b1;
          end
        end
        SB_HIGH: begin
          cnt_d = elapsed;
          if (fall) begin
            if (in_span(elapsed, win.per_lo, win.per_hi)) pass = 1'b1;
            else                                           fail = 1'b1;
          end else if (elapsed > win.per_hi) begin
            fail = 1'b1;
          end
        end
        default: st_d = SB_IDLE;
      endcase
      if (pass || fail) st_d = SB_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SB_IDLE;
      cnt_q     <= '0;
      ok_q      <= 1'b0;
      err_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cnt_q     <= cnt_d;
      ok_q      <= pass;
      err_q     <= fail & ~msg_open;
      restart_q <= pass & msg_open;
    end
  end

  assign busy = (st_q != SB_IDLE);

endmodule

// File: rtl/cec_start_validator.sv
module cec_start_validator
  import cec_sb_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int RISE_EARLY_BASE = 115,
  parameter int RISE_LATE_BASE  = 128,
  parameter int PER_SHORT_BASE  = 141,
  parameter int PER_LONG_BASE   = 154
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             cec_line,
  input  logic             msg_open,
  input  logic [ADJ_W-1:0] adj_rise_early,
  input  logic [ADJ_W-1:0] adj_rise_late,
  input  logic [ADJ_W-1:0] adj_per_short,
  input  logic [ADJ_W-1:0] adj_per_long,
  output logic             start_ok,
  output logic             start_err,
  output logic             restart_err
);

  // named internal events, visible to the bound checker
  logic fall_ev;
  logic rise_ev;
  logic win_load;
  logic busy;
  win_t win_q;

  cec_sb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .line_raw (cec_line),
    .fall     (fall_ev),
    .rise     (rise_ev)
  );

  cec_sb_window #(
    .RISE_EARLY_BASE (RISE_EARLY_BASE),
    .RISE_LATE_BASE  (RISE_LATE_BASE),
    .PER_SHORT_BASE  (PER_SHORT_BASE),
    .PER_LONG_BASE   (PER_LONG_BASE)
  ) u_win (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (win_load),
    .adj_rise_early (adj_rise_early),
    .adj_rise_late  (adj_rise_late),
    .adj_per_short  (adj_per_short),
    .adj_per_long   (adj_per_long),
    .win_q          (win_q)
  );

  cec_sb_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .tick      (tick),
    .fall      (fall_ev),
    .rise      (rise_ev),
    .msg_open  (msg_open),
    .win       (win_q),
    .load      (win_load),
    .busy      (busy),
    .ok_q      (start_ok),
    .err_q     (start_err),
    .restart_q (restart_err)
  );

endmodule

// File: rtl/cec_sb_chk.sv
module cec_sb_chk
  import cec_sb_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic tick,
  input logic msg_open,
  input logic start_ok,
  input logic start_err,
  input logic restart_err,
  input logic busy,
  input win_t win
);

  // R3
  ok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !start_ok);

  // R3
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ok && start_err));

  // R3
  ok_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> $past(tick));

  // R4
  err_follows_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> $past(tick));

  // R8
  restart_with_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_err |-> start_ok);

  // R9
  err_quiet_in_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> !$past(msg_open));

  // R10
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> !(start_ok || start_err || restart_err));

  // R7
  window_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(win));

endmodule

bind cec_start_validator cec_sb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en          (en),
  .tick        (tick),
  .msg_open    (msg_open),
  .start_ok    (start_ok),
  .start_err   (start_err),
  .restart_err (restart_err),
  .busy        (busy),
  .win         (win_q)
);

// File: tb/tb_cec_start_validator.sv
module tb_cec_start_validator;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int IDLE_T     = 180;
  localparam int TAIL_T     = 20;
  localparam int WD_CYCLES  = 150000;

  localparam logic [2:0] E_OK  = 3'b010;
  localparam logic [2:0] E_ERR = 3'b001;
  localparam logic [2:0] E_OKR = 3'b110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic tick = 1'b0;
  logic cec_line = 1'b1;
  logic msg_open = 1'b0;
  logic [2:0] adj_re = '0, adj_rl = '0, adj_ps = '0, adj_pl = '0;
  logic start_ok, start_err, restart_err;

  typedef struct {
    logic [2:0] code;
    string      req;
  } exp_t;

  exp_t sbq[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   n_pulse = 0;
  int   div = 0;
  bit   done = 0;

  cec_start_validator dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .en             (en),
    .tick           (tick),
    .cec_line       (cec_line),
    .msg_open       (msg_open),
    .adj_rise_early (adj_re),
    .adj_rise_late  (adj_rl),
    .adj_per_short  (adj_ps),
    .adj_per_long   (adj_pl),
    .start_ok       (start_ok),
    .start_err      (start_err),
    .restart_err    (restart_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (div == TICK_DIV-1) begin div <= 0; tick <= 1'b1; end
    else begin div <= div + 1; tick <= 1'b0; end
  end

  task automatic check(bit cond, string req, string what, int act, int exp);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(logic [2:0] code, string req);
    exp_t e;
    e.code = code;
    e.req  = req;
    sbq.push_back(e);
  endtask

  // returns just after the n-th strobe edge
  task automatic wait_ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    #1;
  endtask

  // fall, low for low_t ticks, rise; if close, fall at total_t then short tail
  task automatic shape(int low_t, int total_t, bit close);
    cec_line = 1'b0;
    wait_ticks(low_t);
    cec_line = 1'b1;
    if (close) begin
      wait_ticks(total_t - low_t);
      cec_line = 1'b0;
      wait_ticks(TAIL_T);
      cec_line = 1'b1;
    end
    wait_ticks(IDLE_T);
  endtask

  // monitor: pops one expected item per produced pulse
  always @(negedge clk) begin
    if (rst_n && (start_ok || start_err || restart_err)) begin
      logic [2:0] got;
      got = {restart_err, start_ok, start_err};
      n_pulse++;
      if (sbq.size() == 0) begin
        check(1'b0, "R6", "unexpected pulse", int'(got), 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check(got == e.code, e.req, "pulse code", int'(got), int'(e.code));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int p0;
    repeat (5) @(posedge clk);
    #1;
    // R1: quiet during reset
    check({start_ok, start_err, restart_err} == 3'b000, "R1", "outputs in reset",
          int'({restart_err, start_ok, start_err}), 0);
    rst_n = 1'b1;
    wait_ticks(4);
    check({start_ok, start_err, restart_err} == 3'b000, "R1", "outputs after reset",
          int'({restart_err, start_ok, start_err}), 0);

    // R3: nominal start bit
    push(E_OK, "R3"); shape(120, 150, 1);
    // R2: both lower bounds exactly
    push(E_OK, "R2"); shape(115, 141, 1);
    // R2: both upper bounds exactly
    push(E_OK, "R2"); shape(128, 154, 1);
    // R4: rise one tick early
    push(E_ERR, "R4"); shape(114, 0, 0);
    // R4 / R6: line held low past the late bound; later rise ignored
    push(E_ERR, "R4"); shape(140, 0, 0);
    // R5 / R6: period too short; tail rise ignored
    push(E_ERR, "R5"); shape(120, 140, 1);
    // R5: closing fall one tick late
    push(E_ERR, "R5"); shape(120, 155, 1);
    // R5: no closing fall at all
    push(E_ERR, "R5"); shape(120, 0, 0);

    // R2: full adjustment widens all four bounds
    adj_re = 3'd7; adj_rl = 3'd7; adj_ps = 3'd7; adj_pl = 3'd7;
    wait_ticks(2);
    push(E_OK,  "R2"); shape(108, 134, 1);
    push(E_OK,  "R2"); shape(135, 161, 1);
    push(E_ERR, "R2"); shape(107, 0, 0);
    adj_re = '0; adj_rl = '0; adj_ps = '0; adj_pl = '0;
    wait_ticks(2);

    // R7: late bound raised mid-bit must not rescue a rise at 133
    push(E_ERR, "R7");   // timeout at 129 with captured bound 128
    push(E_ERR, "R7");   // fall at 150 then opens a candidate that rises at 20
    cec_line = 1'b0;
    wait_ticks(50);
    adj_rl = 3'd7;
    wait_ticks(83);
    cec_line = 1'b1;
    wait_ticks(17);
    cec_line = 1'b0;
    wait_ticks(TAIL_T);
    cec_line = 1'b1;
    wait_ticks(IDLE_T);
    adj_rl = '0;

    // R8: valid start while a message is open
    msg_open = 1'b1;
    push(E_OKR, "R8"); shape(120, 150, 1);
    // R9: rejected edge while a message is open stays silent
    p0 = n_pulse;
    shape(100, 0, 0);
    check(n_pulse == p0, "R9", "pulses on rejected edge in message", n_pulse - p0, 0);
    msg_open = 1'b0;

    // R10: disabled block ignores a valid start bit
    en = 1'b0;
    p0 = n_pulse;
    shape(120, 150, 1);
    check(n_pulse == p0, "R10", "pulses while disabled", n_pulse - p0, 0);
    en = 1'b1;
    wait_ticks(4);
    push(E_OK, "R10"); shape(120, 150, 1);

    check(sbq.size() == 0, "R3", "expected pulses left over", sbq.size(), 0);
    finish_run();
  end

endmodule